// File: doc/BRIEF.md
# Sequential Integer Divide Unit with Condition Flags

This block performs the integer divide step of a processor pipeline. It handles unsigned and signed divides in three shapes. The word shape divides a W-bit dividend by a W/2-bit divisor. The long shape divides W bits by W bits. The wide long shape divides a 2W-bit dividend, held in a register pair, by a W-bit divisor. W defaults to 32.

The issuing stage supplies the following on a single `start` pulse:
- the operand values;
- the quotient and remainder register selectors;
- the current N, Z and V flags;
- the address of the instruction.

The unit then runs a bit-serial restoring divide over magnitudes and corrects the signs at the end. It delivers the results through one register-file write port and presents a new N/Z/V/C set on the cycle `done` pulses. A zero divisor produces a one-cycle trap indication that carries the captured instruction address. Building the trap frame is left to the exception logic.

Top module: `divflag_unit`

## Requirements
- R1: Every completed operation presents `flags_out[0]` (C) as 0. This covers normal results, overflow and zero divisor. `flags_out` is ordered {N,Z,V,C} from bit 3 down to bit 0.
- R2: A zero divisor ends the operation with `trap` and `done` high in the same cycle.
  - For the word shape, only divisor bits W/2-1:0 are tested.
  - `trap_pc` equals the `pc_in` captured at start.
  - No write occurs.
  - N, Z and V equal `flags_in` {N,Z,V} (bit 2 down to bit 0) captured at start.
- R3: A word divide without overflow makes a single write to `q_sel`. Bits W-1:W/2 hold the W/2-bit remainder and bits W/2-1:0 hold the W/2-bit quotient. The divisor's upper W/2 bits and `op_wide` are ignored.
- R4: Word overflow occurs in two cases:
  - unsigned: the quotient exceeds 2^(W/2)-1;
  - signed: the quotient lies outside [-2^(W/2-1), 2^(W/2-1)-1].
- R5: On overflow the outputs are as follows:
  - V is 1 and Z is 0.
  - N equals the captured `flags_in` N.
  - No register write occurs.
- R6: Without overflow or trap, V is 0. N and Z follow the quotient:
  - word shape: the W/2-bit quotient (sign bit, all-zero test);
  - long shapes: the W-bit quotient.
- R7: The long shapes take their dividend as follows:
  - the wide long shape uses `src_hi` as the upper W bits and `src_lo` as the lower W bits;
  - the plain long shape uses `src_lo` alone.
  - Overflow occurs when the quotient leaves the unsigned or signed W-bit range. This includes the signed case of the most negative value divided by -1.
- R8: A long divide without overflow writes twice in consecutive cycles. The remainder goes to `r_sel` first and the quotient goes to `q_sel` second, with `done` high. When the selectors are equal, the quotient is therefore the final content.
- R9: The quotient truncates toward zero. A nonzero remainder has the sign of the dividend.
- R10: `start` is accepted only while `busy` is low and is ignored otherwise.
  - `busy` is high from the cycle after acceptance through the `done` cycle.
  - `done` is a single-cycle pulse.
  - After reset, `busy`, `done`, `wr_en` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_long | input | 1 | 1 selects a long shape, 0 the word shape |
| op_signed | input | 1 | 1 selects a signed divide |
| op_wide | input | 1 | With op_long, selects the 2W-bit dividend |
| src_lo | input | W | Quotient register value (low dividend half) |
| src_hi | input | W | Remainder register value (high dividend half) |
| divisor | input | W | Divisor operand |
| q_sel | input | SEL | Quotient destination selector |
| r_sel | input | SEL | Remainder destination selector |
| flags_in | input | 3 | Current {N,Z,V} |
| pc_in | input | AW | Address of the divide instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse; flags_out valid |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | SEL | Register write selector |
| wr_data | output | W | Register write data |
| flags_out | output | 4 | New {N,Z,V,C} |
| trap | output | 1 | Divide-by-zero trap pulse |
| trap_pc | output | AW | Captured instruction address for the trap |

## Verification
The bench uses an 8-bit configuration. For the word shape it sweeps every dividend against every 4-bit divisor, both signed and unsigned. This covers all zero-divisor cases, both overflow boundaries and every sign combination that separates truncation from flooring. Random garbage in the ignored divisor bits shows whether the word path looks only at its low half.

The plain and wide long shapes get pseudo-random operands. The high dividend halves are biased toward zero and all-ones so that results fall on both sides of the W-bit limit.

Directed cases cover the following:
- most-negative divided by -1, in both long shapes;
- equal quotient and remainder selectors, which shows the write order;
- a second `start` raised mid-operation, which must leave the result unchanged.

// File: rtl/divflag_unit.sv
module divflag_unit #(
  parameter int W   = 32,
  parameter int SEL = 3,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op_long,
  input  logic           op_signed,
  input  logic           op_wide,
  input  logic [W-1:0]   src_lo,
  input  logic [W-1:0]   src_hi,
  input  logic [W-1:0]   divisor,
  input  logic [SEL-1:0] q_sel,
  input  logic [SEL-1:0] r_sel,
  input  logic [2:0]     flags_in,
  input  logic [AW-1:0]  pc_in,
  output logic           busy,
  output logic           done,
  output logic           wr_en,
  output logic [SEL-1:0] wr_sel,
  output logic [W-1:0]   wr_data,
  output logic [3:0]     flags_out,
  output logic           trap,
  output logic [AW-1:0]  trap_pc
);
  localparam int H  = W / 2;
  localparam int W2 = 2 * W;
  localparam int CW = $clog2(W2 + 1);
  localparam logic [W2-1:0] ONE2 = {{(W2-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]  ONE1 = {{(W-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_POST, S_WRQ, S_ZERO} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    rem, dvs;
  logic [W2-1:0]   quo;
  logic            q_neg, r_neg, is_long, is_signed;
  logic [SEL-1:0]  qs, rs;
  logic [2:0]      prev;
  logic [AW-1:0]   pc_q;

  // operand capture
  logic            wide_in, sd_in, sv_in;
  logic [W-1:0]    dv_raw, dv_mag;
  logic [W2-1:0]   dd_raw, dd_mag;

  assign wide_in = op_long & op_wide;
  assign dv_raw  = op_long ? divisor : {{H{op_signed & divisor[H-1]}}, divisor[H-1:0]};
  assign dd_raw  = wide_in ? {src_hi, src_lo} : {{W{op_signed & src_lo[W-1]}}, src_lo};
  assign sd_in   = op_signed & dd_raw[W2-1];
  assign sv_in   = op_signed & dv_raw[W-1];
  assign dd_mag  = sd_in ? ~dd_raw + ONE2 : dd_raw;
  assign dv_mag  = sv_in ? ~dv_raw + ONE1 : dv_raw;

  // one restoring step
  logic [W:0]      rem_sh, rem_sub;
  logic            ge;
  assign rem_sh  = {rem, quo[W2-1]};
  assign ge      = rem_sh >= {1'b0, dvs};
  assign rem_sub = rem_sh - {1'b0, dvs};

  // result fixup
  logic [W2-1:0]   q_val, lim;
  logic [W-1:0]    r_val;
  logic            ovf, n_res, z_res;
  assign q_val = q_neg ? ~quo + ONE2 : quo;
  assign r_val = r_neg ? ~rem + ONE1 : rem;

  always_comb begin
    if (!is_signed) lim = (ONE2 << (is_long ? W : H)) - ONE2;
    else            lim = (ONE2 << ((is_long ? W : H) - 1)) - (q_neg ? '0 : ONE2);
  end
  assign ovf   = quo > lim;
  assign n_res = is_long ? q_val[W-1] : q_val[H-1];
  assign z_res = is_long ? (q_val[W-1:0] == '0) : (q_val[H-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; rem <= '0; quo <= '0; dvs <= '0;
      q_neg <= 1'b0; r_neg <= 1'b0; is_long <= 1'b0; is_signed <= 1'b0;
      qs <= '0; rs <= '0; prev <= '0; pc_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          qs <= q_sel; rs <= r_sel; prev <= flags_in; pc_q <= pc_in;
          is_long <= op_long; is_signed <= op_signed;
          q_neg <= sd_in ^ sv_in; r_neg <= sd_in;
          dvs <= dv_mag; rem <= '0;
          quo <= wide_in ? dd_mag : {dd_mag[W-1:0], {W{1'b0}}};
          cnt <= wide_in ? CW'(W2) : CW'(W);
          st  <= (dv_raw == '0) ? S_ZERO : S_RUN;
        end
        S_RUN: begin
          rem <= ge ? rem_sub[W-1:0] : rem_sh[W-1:0];
          quo <= {quo[W2-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_POST;
        end
        S_POST:  st <= (is_long && !ovf) ? S_WRQ : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = st != S_IDLE;
  assign trap    = st == S_ZERO;
  assign trap_pc = pc_q;
  assign wr_en   = (st == S_POST && !ovf) || st == S_WRQ;
  assign wr_sel  = (st == S_POST && is_long) ? rs : qs;
  assign wr_data = (st == S_WRQ) ? q_val[W-1:0]
                 : is_long ? r_val : {r_val[H-1:0], q_val[H-1:0]};
  assign done    = (st == S_POST && (ovf || !is_long)) || st == S_WRQ || st == S_ZERO;

  always_comb begin
    if (st == S_ZERO) flags_out = {prev, 1'b0};
    else if (ovf)     flags_out = {prev[2], 1'b0, 1'b1, 1'b0};
    else              flags_out = {n_res, z_res, 1'b0, 1'b0};
  end
endmodule

module divflag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wr_en,
  input logic       trap,
  input logic [3:0] flags_out
);
  p_carry_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_out[0]);
  p_zero_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done && !wr_en);
  p_ovf_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && flags_out[1] && !trap |-> !wr_en && !$past(wr_en));
  p_ovf_zclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && flags_out[1] && !trap |-> !flags_out[2]);
  p_rem_then_quo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !done |=> wr_en && done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind divflag_unit divflag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .trap(trap), .flags_out(flags_out)
);

// File: tb/divflag_unit_tb.sv
`timescale 1ns/1ps
module divflag_unit_tb;
  localparam int W = 8, H = 4, SEL = 3, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic op_long = 0, op_signed = 0, op_wide = 0;
  logic [W-1:0] src_lo = '0, src_hi = '0, divisor = '0;
  logic [SEL-1:0] q_sel = '0, r_sel = '0;
  logic [2:0] flags_in = '0;
  logic [AW-1:0] pc_in = '0;
  logic busy, done, wr_en, trap;
  logic [SEL-1:0] wr_sel;
  logic [W-1:0] wr_data;
  logic [3:0] flags_out;
  logic [AW-1:0] trap_pc;

  int total = 0, bad = 0;
  bit ended = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  divflag_unit #(.W(W), .SEL(SEL), .AW(AW)) u_dut (
    .clk, .rst_n, .start, .op_long, .op_signed, .op_wide, .src_lo, .src_hi,
    .divisor, .q_sel, .r_sel, .flags_in, .pc_in, .busy, .done, .wr_en,
    .wr_sel, .wr_data, .flags_out, .trap, .trap_pc);

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic longint sx(longint v, int n);
    return ((v >> (n - 1)) & 1) ? v - (longint'(1) << n) : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit lng, input bit sg, input bit wd,
                        input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] dv,
                        input logic [SEL-1:0] qs, input logic [SEL-1:0] rs,
                        input logic [2:0] fin, input logic [AW-1:0] pc, input bit glitch);
    longint dd, dvv, q, r, exp_flags, exp_w[2], mk;
    bit zero, ovf, fin_loop;
    int nw, cyc, exp_n;
    longint act_w[4];
    logic [3:0] got_flags;
    logic got_trap;
    logic [AW-1:0] got_pc;
    string wtag, ftag;

    // model
    if (!lng) dvv = sg ? sx(longint'(dv[H-1:0]), H) : longint'(dv[H-1:0]);
    else      dvv = sg ? sx(longint'(dv), W) : longint'(dv);
    if (lng && wd) dd = sg ? sx((longint'(hi) << W) | longint'(lo), 2*W) : (longint'(hi) << W) | longint'(lo);
    else           dd = sg ? sx(longint'(lo), W) : longint'(lo);
    zero = (dvv == 0);
    q = zero ? 0 : dd / dvv;
    r = zero ? 0 : dd % dvv;
    if (!lng) ovf = sg ? (q < -8 || q > 7) : (q > 15);
    else      ovf = sg ? (q < -128 || q > 127) : (q > 255);
    mk = lng ? 255 : 15;
    if (zero)     exp_flags = {fin, 1'b0};
    else if (ovf) exp_flags = {fin[2], 3'b010};
    else          exp_flags = {((q & mk) >> (lng ? W-1 : H-1)) & 1 ? 1'b1 : 1'b0,
                               (q & mk) == 0 ? 1'b1 : 1'b0, 2'b00};
    exp_n = (zero || ovf) ? 0 : (lng ? 2 : 1);
    if (lng) begin
      exp_w[0] = (longint'(rs) << W) | (r & 255);
      exp_w[1] = (longint'(qs) << W) | (q & 255);
    end else begin
      exp_w[0] = (longint'(qs) << W) | (((r & 15) << H) | (q & 15));
      exp_w[1] = 0;
    end
    wtag = zero ? "R2" : ovf ? (lng ? "R7" : "R4") : (sg ? "R9" : (lng ? "R8" : "R3"));
    ftag = zero ? "R2" : ovf ? "R5" : "R6";

    // drive
    @(negedge clk);
    op_long = lng; op_signed = sg; op_wide = wd; src_hi = hi; src_lo = lo;
    divisor = dv; q_sel = qs; r_sel = rs; flags_in = fin; pc_in = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy", busy, 1);
    nw = 0; cyc = 0; fin_loop = 0; got_flags = '0; got_trap = 0; got_pc = '0;
    while (!fin_loop) begin
      if (wr_en === 1'b1 && nw < 4) begin act_w[nw] = (longint'(wr_sel) << W) | longint'(wr_data); nw++; end
      if (done === 1'b1) begin
        got_flags = flags_out; got_trap = trap; got_pc = trap_pc; fin_loop = 1;
      end else begin
        if (glitch && cyc == 0) begin
          start = 1'b1; src_lo = ~lo; src_hi = ~hi; divisor = dv ^ 8'h5A; q_sel = ~qs; r_sel = ~rs;
        end else start = 1'b0;
        @(negedge clk); cyc++;
        if (cyc > 100) begin chk(0, "R10 timeout", cyc, 0); fin_loop = 1; end
      end
    end
    start = 1'b0;
    chk(nw == exp_n, wtag, nw, exp_n);
    if (nw == exp_n) for (int i = 0; i < exp_n; i++) chk(act_w[i] == exp_w[i], wtag, act_w[i], exp_w[i]);
    chk(longint'(got_flags) == exp_flags, ftag, got_flags, exp_flags);
    chk(got_flags[0] == 1'b0, "R1", got_flags[0], 0);
    chk(got_trap == zero, "R2 trap", got_trap, zero);
    if (zero) chk(got_pc == pc, "R2 pc", got_pc, pc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && wr_en === 0 && trap === 0, "R10 reset",
        {busy, done, wr_en, trap}, 0);

    // word shape, exhaustive
    for (int sg = 0; sg < 2; sg++)
      for (int d = 0; d < 16; d++)
        for (int n = 0; n < 256; n++) begin
          logic [31:0] x;
          x = rnd();
          run_op(0, sg[0], x[0], x[15:8], n[7:0], {x[23:20], d[3:0]},
                 x[26:24], x[29:27], x[18:16], x[15:0], 0);
        end

    // plain long shape
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x;
      x = rnd();
      run_op(1, x[31], 0, x[15:8], x[7:0], (i % 5 == 0) ? 8'h00 : x[23:16],
             x[26:24], x[29:27], x[30:28], x[15:0], 0);
    end

    // wide long shape
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x;
      logic [W-1:0] hi;
      x = rnd();
      hi = (i % 3 == 0) ? x[15:8] : (i % 3 == 1 ? 8'h00 : 8'hFF);
      run_op(1, x[31], 1, hi, x[7:0], (i % 7 == 0) ? 8'h00 : x[23:16],
             x[26:24], x[29:27], x[30:28], x[15:0], 0);
    end

    // directed corners
    run_op(1, 1, 0, 8'h00, 8'h80, 8'hFF, 3'd1, 3'd2, 3'b101, 16'h1111, 0); // R7 -128/-1
    run_op(1, 1, 1, 8'h80, 8'h00, 8'hFF, 3'd1, 3'd2, 3'b001, 16'h2222, 0); // R7 wide min/-1
    run_op(1, 0, 1, 8'h07, 8'h00, 8'h07, 3'd1, 3'd2, 3'b100, 16'h3333, 0); // R7 unsigned limit
    run_op(1, 0, 1, 8'h06, 8'hFF, 8'h07, 3'd5, 3'd5, 3'b000, 16'h4444, 0); // R8 shared selector
    run_op(1, 1, 0, 8'h00, 8'h9C, 8'h07, 3'd5, 3'd5, 3'b000, 16'h5555, 0); // R8 R9 shared selector
    run_op(0, 1, 0, 8'h00, 8'hF9, 8'hF2, 3'd3, 3'd4, 3'b111, 16'h6666, 0); // R9 -7/2
    run_op(0, 0, 0, 8'hAA, 8'hFF, 8'hF0, 3'd3, 3'd4, 3'b010, 16'h7777, 0); // R2 word low half zero
    run_op(1, 0, 1, 8'h12, 8'h34, 8'h09, 3'd6, 3'd0, 3'b000, 16'h8888, 1); // R10 start ignored
    run_op(0, 1, 0, 8'h00, 8'h64, 8'h03, 3'd2, 3'd1, 3'b000, 16'h9999, 1); // R10 start ignored

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule